// File: doc/BRIEF.md
# Dual-Processor Channel Mailbox

This block lets two processors signal each other over a small set of one-bit channels. Each processor owns one occupancy flag per channel. A processor raises one of its own flags to post a message on that channel. The peer lowers that flag once it has taken the message, which acknowledges receipt. A sender treats a channel as busy while its own flag is still raised. A receiver finds pending work by looking at the peer's flags.

Both processors reach the block over one shared register bus. Each bus cycle does a single access, and read data is returned in the same cycle. Each processor has its own register window, with an enable register, a write-one command register and a status register. A shared read-only register reports how many channels are built. Each processor also gets two interrupt lines:
- a level receive interrupt, raised while the peer has enabled traffic pending;
- a one-cycle transmit-free pulse, raised when the peer releases one of its flags.

Top module: `mailbox_dual`

## Requirements
- R1: Processor p (0 or 1) has its window at byte address p×0x10. Within a window the enable register is at offset 0x4, the command register at 0x8 and the status register at 0xC. Addresses from 0x020 to 0x3EF, which would belong to a processor id of 2 or more, read as 0 and ignore writes.
- R2: Writing 1 to bit 16+c of processor p's command register sets p's flag for channel c. The flag shows as bit c of p's status register from the next cycle.
- R3: Writing 1 to bit c of processor p's command register clears the peer's flag for channel c. The cleared flag shows in the peer's status register from the next cycle.
- R4: Zero bits written to a command register change nothing. A command register always reads as 0.
- R5: Command bits for channels at or above NUM_CH (default 6) are ignored. Status bits at or above NUM_CH read as 0.
- R6: Address 0x3F0 reads NUM_CH in bits 7:0 and 0 in all other bits.
- R7: rx_irq[p] is high while some channel c has the peer's flag set and bit c of p's enable register set. The level follows the flags and enables from the cycle after the write that changes them.
- R8: txf_irq[p] is high for exactly one cycle, the cycle after a peer write clears a flag of p's that was set, provided bit 16+c of p's enable register is 1. Clearing a flag that is already clear, or a flag whose bit 16+c enable is 0, gives no pulse.
- R9: Reset (synchronous, active low) clears all flags and all enable bits. Both interrupt outputs then read 0.
- R10: An enable register reads back only the implemented bits, c and 16+c for c < NUM_CH. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when no read |
| rx_irq | output | 2 | Receive interrupt per processor, level |
| txf_irq | output | 2 | Transmit-free interrupt per processor, one-cycle pulse |

## Verification
Read data is combinational, so a read is compared in the same cycle it is driven. A write takes effect at the next rising edge, so its flags and rx_irq are compared in the cycle straight after it. txf_irq is also compared in the cycle straight after the write, and again one cycle later to confirm the pulse is a single cycle. The driver drives on the falling edge and queues each expected value in order. The monitor then compares one queued value 2 ns after each falling edge in which a read or an interrupt observation is marked, so every comparison lands in exactly the cycle in which its result is due.

// File: rtl/mbx_pkg.sv
// Shared constants and types for the dual-processor mailbox.
// Assumes a byte-addressed register bus with 32-bit data.
package mbx_pkg;
    localparam int NUM_PROCS  = 2;
    localparam int DATA_W     = 32;
    localparam int SET_SHIFT  = 16;         // upper half of the command word
    localparam int CFG_ADDR   = 'h3F0;
    localparam logic [3:0] OFF_EN   = 4'h4;
    localparam logic [3:0] OFF_CMD  = 4'h8;
    localparam logic [3:0] OFF_STAT = 4'hC;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_EN,
        KIND_CMD,
        KIND_STAT,
        KIND_CFG
    } reg_kind_e;
endpackage

// File: rtl/mbx_addr_dec.sv
// Address decoder: classifies a bus address as one register of one
// processor window, as the channel-count register, or as nothing.
// Assumes ADDR_W >= 12 so that the channel-count address fits.
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic              proc_id
);
    localparam int WIN_BITS = 5;   // two 16-byte windows span 32 bytes

    // Decode the window, then the offset inside it.
    always_comb begin
        kind    = KIND_NONE;
        proc_id = addr[4];
        if (addr == ADDR_W'(CFG_ADDR)) begin
            kind = KIND_CFG;
        end else if (addr[ADDR_W-1:WIN_BITS] == '0) begin
            case (addr[3:0])
                OFF_EN:   kind = KIND_EN;
                OFF_CMD:  kind = KIND_CMD;
                OFF_STAT: kind = KIND_STAT;
                default:  kind = KIND_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_chan_bank.sv
// Channel bank for one processor. It holds that processor's flags and
// its two enable fields, and it drives that processor's interrupts.
// Set requests come from this processor's command writes. Clear requests
// come from the peer's command writes. If both hit the same flag in one
// cycle, the set wins. Assumes NUM_CH <= 16.
module mbx_chan_bank #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] en_rx_in,
    input  logic [NUM_CH-1:0] en_tx_in,
    input  logic              set_we,
    input  logic [NUM_CH-1:0] set_bits,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] peer_occ,
    output logic [NUM_CH-1:0] occ,
    output logic [NUM_CH-1:0] en_rx,
    output logic [NUM_CH-1:0] en_tx,
    output logic              rx_irq,
    output logic              txf_irq
);
    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] released;

    // Qualify the set and clear requests with their write strobes.
    always_comb begin
        set_v    = set_we ? set_bits : '0;
        clr_v    = clr_we ? clr_bits : '0;
        released = occ & clr_v & ~set_v;
    end

    // Flag storage: the set wins over a clear of the same flag.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= (occ & ~clr_v) | set_v;
    end

    // Enable storage: all interrupts are disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_rx <= '0;
            en_tx <= '0;
        end else if (en_we) begin
            en_rx <= en_rx_in;
            en_tx <= en_tx_in;
        end
    end

    // One-cycle transmit-free pulse for each enabled release.
    always_ff @(posedge clk) begin
        if (!rst_n) txf_irq <= 1'b0;
        else        txf_irq <= |(released & en_tx);
    end

    // Receive level: the peer has a flag raised on an enabled channel.
    always_comb rx_irq = |(peer_occ & en_rx);
endmodule

// File: rtl/mailbox_dual.sv
// Top of the dual-processor channel mailbox. It decodes the shared
// register bus, routes command writes to the two channel banks, and
// returns read data in the same cycle. Assumes one access per cycle and
// 1 <= NUM_CH <= 16.
module mailbox_dual
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        rx_irq,
    output logic [1:0]        txf_irq
);
    localparam int CNT_W = 8;

    reg_kind_e             dec_kind;
    logic                  dec_proc;
    logic [NUM_PROCS-1:0]  cmd_we;
    logic [NUM_PROCS-1:0]  en_we;
    logic [NUM_CH-1:0]     occ_q  [NUM_PROCS];
    logic [NUM_CH-1:0]     en_rx  [NUM_PROCS];
    logic [NUM_CH-1:0]     en_tx  [NUM_PROCS];

    mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .kind    (dec_kind),
        .proc_id (dec_proc)
    );

    // Write strobes for the command and enable registers.
    always_comb begin
        cmd_we = '0;
        en_we  = '0;
        if (bus_sel && bus_we) begin
            case (dec_kind)
                KIND_CMD: cmd_we[dec_proc] = 1'b1;
                KIND_EN:  en_we[dec_proc]  = 1'b1;
                default:  ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_bank
        localparam int PEER = NUM_PROCS - 1 - p;
        mbx_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_we    (en_we[p]),
            .en_rx_in (bus_wdata[NUM_CH-1:0]),
            .en_tx_in (bus_wdata[SET_SHIFT +: NUM_CH]),
            .set_we   (cmd_we[p]),
            .set_bits (bus_wdata[SET_SHIFT +: NUM_CH]),
            .clr_we   (cmd_we[PEER]),
            .clr_bits (bus_wdata[NUM_CH-1:0]),
            .peer_occ (occ_q[PEER]),
            .occ      (occ_q[p]),
            .en_rx    (en_rx[p]),
            .en_tx    (en_tx[p]),
            .rx_irq   (rx_irq[p]),
            .txf_irq  (txf_irq[p])
        );
    end

    // Same-cycle read mux. Command words and holes read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (dec_kind)
                KIND_EN: begin
                    bus_rdata[NUM_CH-1:0]           = en_rx[dec_proc];
                    bus_rdata[SET_SHIFT +: NUM_CH]  = en_tx[dec_proc];
                end
                KIND_STAT: bus_rdata[NUM_CH-1:0]    = occ_q[dec_proc];
                KIND_CFG:  bus_rdata[CNT_W-1:0]     = CNT_W'(NUM_CH);
                default:   bus_rdata                = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_chk.sv
// Property checker for mailbox_dual. It decodes command writes on its
// own and relates them to the flags and interrupts over time.
module mbx_chk #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] occ0,
    input logic [NUM_CH-1:0] occ1,
    input logic [1:0]        rx_irq,
    input logic [1:0]        txf_irq
);
    logic wr_cmd0, wr_cmd1;
    // Independent decode of the two command addresses.
    always_comb begin
        wr_cmd0 = bus_sel && bus_we && (bus_addr == ADDR_W'('h008));
        wr_cmd1 = bus_sel && bus_we && (bus_addr == ADDR_W'('h018));
    end

    // R2: requested set bits are raised one cycle after a command write.
    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd0 |=> ((occ0 & $past(bus_wdata[16 +: NUM_CH])) == $past(bus_wdata[16 +: NUM_CH])));

    // R3: a clear from processor 1 lowers processor 0's flags.
    a_r3_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd1 |=> ((occ0 & $past(bus_wdata[NUM_CH-1:0])) == '0));

    // R4: flags only move on a command write.
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cmd0 || wr_cmd1) |=> ($stable(occ0) && $stable(occ1)));

    // R8: a transmit-free pulse implies a flag of that processor just fell.
    a_r8_txf_on_fall0: assert property (@(posedge clk) disable iff (!rst_n)
        txf_irq[0] |-> (($past(occ0) & ~occ0) != '0));
    a_r8_txf_on_fall1: assert property (@(posedge clk) disable iff (!rst_n)
        txf_irq[1] |-> (($past(occ1) & ~occ1) != '0));

    // R7: a receive interrupt needs a raised peer flag.
    a_r7_rx_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq[0] |-> (occ1 != '0));
endmodule

bind mailbox_dual mbx_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .occ0      (occ_q[0]),
    .occ1      (occ_q[1]),
    .rx_irq    (rx_irq),
    .txf_irq   (txf_irq)
);

// File: tb/mailbox_dual_tb.sv
// Scoreboard bench for mailbox_dual. Driver tasks queue the expected
// values, and a monitor compares them 2 ns after each falling edge.
module mailbox_dual_tb;
    localparam int NUM_CH = 6;
    localparam int ADDR_W = 12;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        rx_irq;
    logic [1:0]        txf_irq;
    logic              obs_irq = 1'b0;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    mailbox_dual #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_irq(rx_irq), .txf_irq(txf_irq)
    );

    task automatic wr(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
        q.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Expected vector is {txf_irq[1], txf_irq[0], rx_irq[1], rx_irq[0]}.
    task automatic irq(input logic [3:0] exp, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {28'd0, exp}; it.tag = tag;
        q.push_back(it);
        obs_irq = 1'b1;
        @(negedge clk);
        obs_irq = 1'b0;
    endtask

    // Monitor: pops one expected item per observed cycle and compares it.
    always @(negedge clk) begin
        #2;
        if ((bus_sel && !bus_we) || obs_irq) begin
            logic [31:0] act;
            act = obs_irq ? {28'd0, txf_irq, rx_irq} : bus_rdata;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", act);
            end else begin
                item_t it;
                it = q.pop_front();
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        rd('h00C, 32'h0, "R9 status0 after reset");
        rd('h01C, 32'h0, "R9 status1 after reset");
        rd('h004, 32'h0, "R9 enable0 after reset");
        irq(4'b0000, "R9 irqs after reset");
        // R6: channel count
        rd('h3F0, 32'd6, "R6 channel count");
        // R10: enable readback
        wr('h004, 32'hFFFF_FFFF);
        rd('h004, 32'h003F_003F, "R10 enable0 readback");
        wr('h014, 32'hFFFF_FFFF);
        // R2 and R7: proc0 posts channels 2 and 5
        wr('h008, 32'h0024_0000);
        irq(4'b0010, "R7 rx1 after set");
        rd('h00C, 32'h24, "R2 status0 set");
        // R4: command reads zero, zero writes do nothing
        rd('h008, 32'h0, "R4 command reads zero");
        wr('h008, 32'h0);
        rd('h00C, 32'h24, "R4 zero write no effect");
        // R5: out-of-range channels ignored
        wr('h008, 32'hFFC0_0000);
        rd('h00C, 32'h24, "R5 high set bits ignored");
        // R3 and R8: proc1 acknowledges channel 2
        wr('h018, 32'h0000_0004);
        irq(4'b0110, "R8 txf0 pulse");
        irq(4'b0010, "R8 txf0 one cycle");
        rd('h00C, 32'h20, "R3 status0 cleared");
        // R8: clearing an already clear flag
        wr('h018, 32'h0000_0004);
        irq(4'b0010, "R8 no pulse on clear flag");
        // R7: proc1 posts channel 0
        wr('h018, 32'h0001_0000);
        irq(4'b0011, "R7 rx0 raised");
        rd('h01C, 32'h1, "R2 status1 set");
        wr('h004, 32'h003F_0000);
        irq(4'b0010, "R7 rx0 masked");
        // R1: unmapped window
        wr('h028, 32'hFFFF_FFFF);
        wr('h024, 32'hFFFF_FFFF);
        rd('h00C, 32'h20, "R1 status0 untouched");
        rd('h01C, 32'h1, "R1 status1 untouched");
        rd('h02C, 32'h0, "R1 unmapped reads zero");
        rd('h024, 32'h0, "R1 unmapped enable zero");
        // R8: release with tx enable off gives no pulse
        wr('h014, 32'h0000_003F);
        wr('h008, 32'h0000_0001);
        irq(4'b0010, "R8 no pulse when disabled");
        rd('h01C, 32'h0, "R3 status1 cleared");
        // R8: release with tx enable on pulses txf1
        wr('h018, 32'h0008_0000);
        wr('h014, 32'h003F_003F);
        wr('h008, 32'h0000_0008);
        irq(4'b1010, "R8 txf1 pulse");
        irq(4'b0010, "R8 txf1 one cycle");
        // R9: reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd('h00C, 32'h0, "R9 status0 after second reset");
        rd('h014, 32'h0, "R9 enable1 after second reset");
        irq(4'b0000, "R9 irqs after second reset");
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule